// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt request lines, latches them into a status word, masks that word with a software-controlled enable word and raises a single request toward a processor whenever any enabled request is outstanding. Each line is fixed at build time as either edge captured (a low-to-high change latches it) or level captured (a high input keeps re-latching it). A vector register names the lowest-numbered outstanding line, so a handler can branch straight to the right service routine.

Software drives the block through a simple single-cycle word-addressed port: one write strobe, a word offset, write data, and combinational read data. Acknowledging takes a bit mask that clears status bits. Enable bits can be set or cleared atomically through dedicated offsets, so no read-modify-write sequence is needed. A two-bit master control separately gates the processor request and the hardware capture of input lines. While capture is off, software may load status directly to inject interrupts for test.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Word offsets select registers as follows: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 enable-set, 5 enable-clear, 6 vector, 7 master control; every access moves a full data word.
- R2: Reading pending returns the bitwise AND of status and enable at all times.
- R3: Reading the vector returns the index of the lowest-numbered set pending bit, or all ones when no pending bit is set.
- R4: irq_o is registered: it is high in the cycle after one in which master bit 0 was set and pending was nonzero, and low otherwise.
- R5: A write to master control stores only data bits 1:0; reading it returns zero in all higher bits.
- R6: While master bit 1 is set, a line whose EDGE_MASK bit is 0 (level) sets its status bit on every clock its input is high, and a line whose EDGE_MASK bit is 1 (edge) sets its status bit only on a clock where its input is high and was low the clock before; while master bit 1 is clear, inputs do not change status.
- R7: Writing acknowledge clears each status bit whose written bit is 1 and leaves the others; a level line still high is latched again in the same cycle.
- R8: Writing enable-set ORs the data into enable; writing enable-clear clears each enable bit written as 1.
- R9: A write to status is ignored while master bit 1 is set; otherwise it replaces status.
- R10: Enable can be written directly at offset 2; writes to pending and vector leave every register unchanged.
- R11: Reads of the write-only offsets 3, 4, 5 and of any offset above 7 return zero, and writes above offset 7 change nothing.
- R12: After reset, status, enable, master control and irq_o are zero and the vector reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | NUM_LINES | Interrupt request inputs |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W | Word offset of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for addr_i |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench sweeps every line position through the vector, both as the only set bit and as the lowest of a contiguous run, so an encoder that picked the highest bit or was off by one would report the wrong index, and an empty pending set must produce all ones rather than zero or 31. It holds an edge line and a level line high across an acknowledge: a design that treated edge lines as levels would re-latch the edge line, and one that treated level lines as edges would lose the still-asserted level request. It writes status with capture both on and off, and raises lines with capture off, catching a design that lets either path through at the wrong time. The request output is sampled the cycle right after master control changes and one cycle later, so an unregistered or doubly registered request is caught.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;

    typedef enum logic [2:0] {
        OFS_STATUS  = 3'd0,
        OFS_PENDING = 3'd1,
        OFS_ENABLE  = 3'd2,
        OFS_ACK     = 3'd3,
        OFS_EN_SET  = 3'd4,
        OFS_EN_CLR  = 3'd5,
        OFS_VECTOR  = 3'd6,
        OFS_MASTER  = 3'd7
    } reg_ofs_e;

    localparam int NUM_REGS       = 8;
    localparam int MASTER_OUT_BIT = 0;
    localparam int MASTER_CAP_BIT = 1;
    localparam int MASTER_W       = 2;

endpackage

// File: rtl/irq_vc_capture.sv
module irq_vc_capture #(
    parameter int                    NUM_LINES = 32,
    parameter logic [NUM_LINES-1:0] EDGE_MASK  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en_i,
    input  logic [NUM_LINES-1:0] lines_i,
    output logic [NUM_LINES-1:0] set_o
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        if (EDGE_MASK[g]) begin : g_edge
            logic prev_d, prev_q;

            always_comb begin
                prev_d   = lines_i[g];
                set_o[g] = cap_en_i & lines_i[g] & ~prev_q;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= prev_d;
            end
        end else begin : g_level
            always_comb set_o[g] = cap_en_i & lines_i[g];
        end
    end

endmodule

// File: rtl/irq_vc_prio.sv
module irq_vc_prio #(
    parameter int NUM_LINES = 32,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] req_i,
    output logic [IDX_W-1:0]     idx_o,
    output logic                 valid_o
);

    always_comb begin
        idx_o   = '0;
        valid_o = |req_i;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vc_pkg::*;
#(
    parameter int                    NUM_LINES = 32,
    parameter int                    DATA_W    = 32,
    parameter int                    ADDR_W    = 4,
    parameter logic [NUM_LINES-1:0] EDGE_MASK  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 irq_o
);

    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    typedef struct packed {
        logic [NUM_LINES-1:0] status;
        logic [NUM_LINES-1:0] enable;
        logic [MASTER_W-1:0]  master;
        logic                 irq;
    } state_t;

    state_t               state_d, state_q;
    logic [NUM_LINES-1:0] status_q, enable_q, pending, cap_set, wval;
    logic [MASTER_W-1:0]  master_q;
    logic [IDX_W-1:0]     vec_idx;
    logic                 vec_valid;
    logic                 in_map;
    reg_ofs_e             ofs;

    assign status_q = state_q.status;
    assign enable_q = state_q.enable;
    assign master_q = state_q.master;
    assign pending  = status_q & enable_q;
    assign in_map   = (addr_i < ADDR_W'(NUM_REGS));
    assign ofs      = reg_ofs_e'(addr_i[2:0]);
    assign wval     = wdata_i[NUM_LINES-1:0];

    irq_vc_capture #(
        .NUM_LINES (NUM_LINES),
        .EDGE_MASK (EDGE_MASK)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en_i (master_q[MASTER_CAP_BIT]),
        .lines_i  (irq_lines_i),
        .set_o    (cap_set)
    );

    irq_vc_prio #(
        .NUM_LINES (NUM_LINES)
    ) u_prio (
        .req_i   (pending),
        .idx_o   (vec_idx),
        .valid_o (vec_valid)
    );

    // next-state: software write first, then hardware capture on top
    always_comb begin
        state_d = state_q;
        if (wr_en_i && in_map) begin
            case (ofs)
                OFS_STATUS: if (!master_q[MASTER_CAP_BIT]) state_d.status = wval;
                OFS_ENABLE: state_d.enable = wval;
                OFS_ACK:    state_d.status = status_q & ~wval;
                OFS_EN_SET: state_d.enable = enable_q | wval;
                OFS_EN_CLR: state_d.enable = enable_q & ~wval;
                OFS_MASTER: state_d.master = wdata_i[MASTER_W-1:0];
                default:    ;
            endcase
        end
        state_d.status = state_d.status | cap_set;
        state_d.irq    = master_q[MASTER_OUT_BIT] && (pending != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        rdata_o = '0;
        if (in_map) begin
            case (ofs)
                OFS_STATUS:  rdata_o = DATA_W'(status_q);
                OFS_PENDING: rdata_o = DATA_W'(pending);
                OFS_ENABLE:  rdata_o = DATA_W'(enable_q);
                OFS_VECTOR:  rdata_o = vec_valid ? DATA_W'(vec_idx) : '1;
                OFS_MASTER:  rdata_o = DATA_W'(master_q);
                default:     rdata_o = '0;
            endcase
        end
    end

    assign irq_o = state_q.irq;

endmodule

// File: rtl/irq_vc_checker.sv
module irq_vc_checker #(
    parameter int NUM_LINES = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    rdata,
    input logic                 irq,
    input logic [NUM_LINES-1:0] status,
    input logic [NUM_LINES-1:0] enable,
    input logic [1:0]           master
);

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ($past(master[0]) && ($past(status & enable) != '0)));

    assert_master_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(7)) |-> (rdata[DATA_W-1:2] == '0));

    assert_vector_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == ADDR_W'(6)) && (rdata != '1)) |-> (rdata < DATA_W'(NUM_LINES)));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == ADDR_W'(3) && !master[1])
        |-> ((status & $past(wdata[NUM_LINES-1:0])) == '0));

    assert_enable_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == ADDR_W'(4))
        |-> ((enable & $past(wdata[NUM_LINES-1:0])) == $past(wdata[NUM_LINES-1:0])));

    assert_status_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == ADDR_W'(0) && master[1])
        |-> (($past(status) & ~status) == '0));

    assert_no_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!master[1] && !(wr_en && addr == ADDR_W'(0)))
        |-> ((status & ~$past(status)) == '0));

endmodule

bind irq_vector_ctrl irq_vc_checker #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en_i),
    .addr   (addr_i),
    .wdata  (wdata_i),
    .rdata  (rdata_o),
    .irq    (irq_o),
    .status (status_q),
    .enable (enable_q),
    .master (master_q)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

    localparam int          NL = 32;
    localparam int          DW = 32;
    localparam int          AW = 4;
    localparam logic [31:0] EM = 32'hFFFF_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lines = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_vector_ctrl #(
        .NUM_LINES (NL),
        .DATA_W    (DW),
        .ADDR_W    (AW),
        .EDGE_MASK (EM)
    ) u_irq_vector_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_lines_i (lines),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = AW'(a);
        #1;
        d = rdata;
    endtask

    task automatic drive_lines(input logic [31:0] v);
        @(negedge clk);
        lines = v;
        @(negedge clk);
    endtask

    function automatic logic [31:0] lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, p, q, lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a, d);
            chk("R12 reset read", d, (a == 6) ? 32'hFFFF_FFFF : 32'h0);
        end
        chk("R12 reset irq", 32'(irq), 32'h0);

        // R5 master keeps two bits
        wr(7, 32'hFFFF_FFFE); rd(7, d); chk("R5 master bits", d, 32'h2);
        wr(7, 32'h0);         rd(7, d); chk("R5 master clear", d, 32'h0);

        // R1 R2 R3 R10 sweep: single bit and run from bit i
        wr(2, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            wr(0, 32'h1 << i);
            rd(6, d); chk("R3 vector single", d, 32'(i));
            wr(0, 32'hFFFF_FFFF << i);
            rd(6, d); chk("R3 vector run", d, 32'(i));
            rd(0, d); chk("R1 status readback", d, 32'hFFFF_FFFF << i);
        end
        wr(0, 32'h0); rd(6, d); chk("R3 vector empty", d, 32'hFFFF_FFFF);

        // R2 R10 patterned status/enable
        lf = 32'hACE1_1234;
        for (int k = 0; k < 24; k++) begin
            p  = lf; lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            q  = lf; lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            wr(0, p); wr(2, q);
            rd(2, d); chk("R10 enable direct", d, q);
            rd(1, d); chk("R2 pending", d, p & q);
            rd(6, d); chk("R3 vector pattern", d, lowest(p & q));
        end

        // R10 writes to pending and vector change nothing
        wr(0, 32'h00F0_0F00); wr(2, 32'h0FF0_FF00);
        wr(1, 32'h0); wr(6, 32'h0);
        rd(0, d); chk("R10 status after pending/vector write", d, 32'h00F0_0F00);
        rd(2, d); chk("R10 enable after pending/vector write", d, 32'h0FF0_FF00);
        rd(1, d); chk("R10 pending recomputed", d, 32'h00F0_0F00);

        // R11 write-only and unmapped offsets
        for (int a = 3; a < 6; a++) begin
            rd(a, d); chk("R11 write-only read", d, 32'h0);
        end
        for (int a = 8; a < 16; a++) begin
            wr(a, 32'hFFFF_FFFF);
            rd(a, d); chk("R11 unmapped read", d, 32'h0);
        end
        rd(0, d); chk("R11 status untouched", d, 32'h00F0_0F00);
        rd(2, d); chk("R11 enable untouched", d, 32'h0FF0_FF00);
        rd(7, d); chk("R11 master untouched", d, 32'h0);

        // R8 atomic enable set/clear
        wr(2, 32'h0);
        wr(4, 32'h0000_000F); wr(4, 32'h8000_00F0);
        rd(2, d); chk("R8 enable set", d, 32'h8000_00FF);
        wr(5, 32'h8000_003C);
        rd(2, d); chk("R8 enable clear", d, 32'h0000_00C3);

        // R7 acknowledge with capture off
        wr(0, 32'hFF00_00FF); wr(3, 32'h0F00_000F);
        rd(0, d); chk("R7 ack clears", d, 32'hF000_00F0);

        // R6 capture off: lines do nothing
        wr(0, 32'h0);
        drive_lines(32'h0001_0020);
        rd(0, d); chk("R6 capture off", d, 32'h0);
        drive_lines(32'h0);

        // R9 status write with capture on, then off
        wr(7, 32'h2); wr(0, 32'h0000_00FF);
        rd(0, d); chk("R9 status locked", d, 32'h0);
        wr(7, 32'h0); wr(0, 32'h0000_00FF);
        rd(0, d); chk("R9 status written", d, 32'h0000_00FF);
        wr(3, 32'hFFFF_FFFF);

        // R6 R7 level line 3 and edge line 20
        wr(7, 32'h2);
        drive_lines(32'h0000_0008);
        rd(0, d); chk("R6 level capture", d, 32'h0000_0008);
        wr(3, 32'h0000_0008);
        rd(0, d); chk("R7 level relatched", d, 32'h0000_0008);
        drive_lines(32'h0010_0008);
        rd(0, d); chk("R6 edge capture", d, 32'h0010_0008);
        wr(3, 32'h0010_0000);
        rd(0, d); chk("R6 edge not relatched", d, 32'h0000_0008);
        @(negedge clk);
        rd(0, d); chk("R6 edge held high stays clear", d, 32'h0000_0008);
        drive_lines(32'h0);
        wr(3, 32'hFFFF_FFFF);
        rd(0, d); chk("R7 all cleared", d, 32'h0);

        // R4 output gating and latency
        wr(7, 32'h0); wr(2, 32'h1); wr(0, 32'h1);
        chk("R4 gated off", 32'(irq), 32'h0);
        wr(7, 32'h1);
        chk("R4 one-cycle latency", 32'(irq), 32'h0);
        @(negedge clk);
        chk("R4 asserted", 32'(irq), 32'h1);
        wr(5, 32'h1);
        @(negedge clk);
        chk("R4 no pending drops", 32'(irq), 32'h0);
        wr(4, 32'h1);
        @(negedge clk);
        chk("R4 reasserted", 32'(irq), 32'h1);
        wr(7, 32'h0);
        @(negedge clk);
        chk("R4 master off drops", 32'(irq), 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule